// File: doc/BRIEF.md
# Strobe-Qualified Bus Capture Across Clock Domains

This block moves a parallel data word from a source that only provides a strobe, unrelated to the system clock, into logic that runs on the system clock. The word is latched into a holding register on the rising edge of the strobe and stays there until the next strobe. Only the strobe crosses into the system clock domain, through a chain of synchronizer flops. A rising-edge detector then turns the synchronized level into a single-cycle load enable. That enable loads the held word into a destination register, and one cycle later a valid pulse marks the new word.

Two front ends can be chosen by parameter. In level mode the strobe itself feeds the synchronizer, so every strobe must stay high for at least one system clock period. In pulse mode a catch flop, set by the strobe edge, feeds the synchronizer instead. Its asynchronous clear fires only after the synchronized copy has gone high and the strobe has dropped, so strobes narrower than a clock period are not lost.

The output side is a plain valid pulse without a ready input. The receiver must accept the word in the cycle that valid is high, because there is no back-pressure. The sender must space strobes far enough apart that the synchronizer has returned low before the next one arrives.

Top module: `async_bus_capture`

## Requirements
- R1: While reset is high, `dout_o` and `valid_o` are driven to zero, and the holding register and catch flop are cleared.
- R2: The delivered word is the value of `bus_i` at the rising edge of `strb_i`. Changes to `bus_i` after that edge and before the next rising edge do not alter the delivered word.
- R3: Each rising edge of `strb_i` produces exactly one `valid_o` pulse, provided strobes are spaced by at least eight system clock periods.
- R4: With `SYNC_STAGES` = 2, `valid_o` is first seen high after the third rising system clock edge that follows the strobe rising edge, which is `SYNC_STAGES` + 1 edges.
- R5: `dout_o` changes only in the cycle in which `valid_o` is high and keeps its value while `valid_o` is low.
- R6: Words leave in the order in which their strobes arrived.
- R7: With `MODE` = pulse, strobes narrower than one system clock period, down to 1 ns, are each delivered once.
- R8: `valid_o` is never high in two consecutive cycles.
- R9: A strobe held high for many system clock periods delivers a single word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high reset, synchronous in the system domain and asynchronous clear for the strobe-domain flops |
| strb_i | input | 1 | Source strobe; its rising edge latches the bus |
| bus_i | input | DATA_W | Data word from the source |
| dout_o | output | DATA_W | Word captured in the system domain |
| valid_o | output | 1 | One-cycle pulse marking a new `dout_o` |

## Verification
The bench changes the bus one nanosecond after each strobe edge. A design that let the bus through without holding it would deliver the inverted word. It holds some strobes high for many clock periods, and a detector that responds to the level instead of the edge would emit a burst of valid pulses or reload the word. It sends 1 to 3 ns strobes to the pulse-mode instance, which a front end without the catch flop would drop silently. It also counts the edges from strobe to valid, so an extra or missing synchronizer stage, or a valid that is not aligned with the data, shows up as a latency other than three.

// File: rtl/bcap_pkg.sv
`timescale 1ns/100ps
package bcap_pkg;
  typedef enum logic {
    CAPT_LEVEL = 1'b0,
    CAPT_PULSE = 1'b1
  } capt_mode_e;
endpackage

// File: rtl/bcap_src_hold.sv
`timescale 1ns/100ps
// Strobe-domain front end: word holding register plus optional pulse catcher.
module bcap_src_hold
  import bcap_pkg::*;
#(
  parameter int unsigned W    = 8,
  parameter capt_mode_e  MODE = CAPT_PULSE
) (
  input  logic         strb_i,
  input  logic         rst,
  input  logic [W-1:0] bus_i,
  input  logic         sync_hi,
  output logic [W-1:0] held_o,
  output logic         flag_o
);

  // Word is frozen on the strobe edge and stays until the next edge.
  always_ff @(posedge strb_i or posedge rst) begin
    if (rst) held_o <= '0;
    else     held_o <= bus_i;
  end

  generate
    if (MODE == CAPT_PULSE) begin : g_pulse
      logic clr;
      logic catch_q;
      // Clear only once the system side has seen the flag and the strobe is low.
      assign clr = rst | (sync_hi & ~strb_i);
      always_ff @(posedge strb_i or posedge clr) begin
        if (clr) catch_q <= 1'b0;
        else     catch_q <= 1'b1;
      end
      assign flag_o = catch_q;
    end else begin : g_level
      assign flag_o = strb_i;
    end
  endgenerate

endmodule

// File: rtl/bcap_sync_chain.sv
`timescale 1ns/100ps
// Multi-flop synchronizer for a single level.
module bcap_sync_chain #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] q;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) q[i] <= q[i-1];
    end
  end

  assign q_o = q[STAGES-1];

endmodule

// File: rtl/bcap_edge_pulse.sv
`timescale 1ns/100ps
// Rising-edge one-shot on a synchronized level.
module bcap_edge_pulse (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic en_o
);

  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl_i;
  end

  assign en_o = lvl_i & ~prev_q;

endmodule

// File: rtl/bcap_dst_reg.sv
`timescale 1ns/100ps
// System-domain destination register with aligned valid.
module bcap_dst_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o,
  output logic         valid_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= en_i;
      if (en_i) dout_o <= din_i;
    end
  end

endmodule

// File: rtl/async_bus_capture.sv
`timescale 1ns/100ps
module async_bus_capture
  import bcap_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter capt_mode_e  MODE        = CAPT_PULSE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strb_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              valid_o
);

  logic [DATA_W-1:0] held_bus;
  logic              src_flag;
  logic              sync_lvl;
  logic              load_en;

  bcap_src_hold #(.W(DATA_W), .MODE(MODE)) u_src (
    .strb_i (strb_i),
    .rst    (rst),
    .bus_i  (bus_i),
    .sync_hi(sync_lvl),
    .held_o (held_bus),
    .flag_o (src_flag)
  );

  bcap_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk),
    .rst(rst),
    .d_i(src_flag),
    .q_o(sync_lvl)
  );

  bcap_edge_pulse u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl_i(sync_lvl),
    .en_o (load_en)
  );

  bcap_dst_reg #(.W(DATA_W)) u_dst (
    .clk    (clk),
    .rst    (rst),
    .en_i   (load_en),
    .din_i  (held_bus),
    .dout_o (dout_o),
    .valid_o(valid_o)
  );

endmodule

// File: rtl/bcap_checker.sv
`timescale 1ns/100ps
module bcap_checker #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         sync_lvl,
  input logic         valid_o,
  input logic [W-1:0] dout_o
);

  // R1: reset clears the outputs
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!valid_o && dout_o == '0));

  // R8: valid lasts a single cycle
  a_r8_single_cycle: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  // R5: data stays put between valid pulses
  a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> $stable(dout_o));

  // R3: every synchronized rise yields a valid next cycle
  a_r3_rise_gives_valid: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_lvl) |=> valid_o);

  // R4: valid only follows a fresh synchronized rise
  a_r4_valid_after_rise: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> ($past(sync_lvl) && !$past(sync_lvl, 2)));

endmodule

bind async_bus_capture bcap_checker #(.W(DATA_W)) u_bcap_chk (
  .clk     (clk),
  .rst     (rst),
  .sync_lvl(sync_lvl),
  .valid_o (valid_o),
  .dout_o  (dout_o)
);

// File: tb/test_async_bus_capture.sv
`timescale 1ns/100ps
module test_async_bus_capture;
  import bcap_pkg::*;

  localparam int W    = 8;
  localparam int NVEC = 10;
  localparam logic [W-1:0] VEC_WORD [NVEC] = '{8'hA5, 8'h3C, 8'h00, 8'hFF, 8'h81,
                                               8'h7E, 8'h12, 8'hC3, 8'h5A, 8'h01};
  localparam int VEC_HI  [NVEC] = '{6, 7, 9, 12, 6, 8, 11, 14, 10, 13};
  localparam int VEC_GAP [NVEC] = '{13, 21, 9, 33, 17, 26, 11, 40, 19, 8};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strb_a = 1'b0, strb_b = 1'b0;
  logic [W-1:0] bus = '0;
  logic [W-1:0] dout_a, dout_b;
  logic val_a, val_b;

  always #2.5 clk = ~clk;   // 200 MHz

  async_bus_capture #(.DATA_W(W), .SYNC_STAGES(2), .MODE(CAPT_LEVEL)) i_async_bus_capture (
    .clk(clk), .rst(rst), .strb_i(strb_a), .bus_i(bus), .dout_o(dout_a), .valid_o(val_a));

  async_bus_capture #(.DATA_W(W), .SYNC_STAGES(2), .MODE(CAPT_PULSE)) i_async_bus_capture_sp (
    .clk(clk), .rst(rst), .strb_i(strb_b), .bus_i(bus), .dout_o(dout_b), .valid_o(val_b));

  int n_chk = 0, n_err = 0;
  logic [W-1:0] exp_a [64];
  logic [W-1:0] exp_b [64];
  int wr_a = 0, rd_a = 0, wr_b = 0, rd_b = 0;
  logic pv_a = 1'b0, pv_b = 1'b0;
  logic [W-1:0] last_a = '0, last_b = '0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Output monitor, away from the active edge
  always @(negedge clk) begin
    if (rst) begin
      pv_a = 1'b0; pv_b = 1'b0; last_a = dout_a; last_b = dout_b;
    end else begin
      if (val_a) begin
        chk(dout_a == exp_a[rd_a % 64], "R6", "order/value A", int'(dout_a), int'(exp_a[rd_a % 64]));
        rd_a++;
      end
      if (val_b) begin
        chk(dout_b == exp_b[rd_b % 64], "R6", "order/value B", int'(dout_b), int'(exp_b[rd_b % 64]));
        rd_b++;
      end
      if (val_a && pv_a) chk(1'b0, "R8", "valid A two cycles", 1, 0);
      if (val_b && pv_b) chk(1'b0, "R8", "valid B two cycles", 1, 0);
      if (!val_a && dout_a != last_a) chk(1'b0, "R5", "dout A moved without valid", int'(dout_a), int'(last_a));
      if (!val_b && dout_b != last_b) chk(1'b0, "R5", "dout B moved without valid", int'(dout_b), int'(last_b));
      pv_a = val_a; pv_b = val_b; last_a = dout_a; last_b = dout_b;
    end
  end

  task automatic send(input logic [W-1:0] w, input int hi, input int gap, input bit use_a, input bit use_b);
    bus = w;
    #1;
    if (use_a) begin exp_a[wr_a % 64] = w; wr_a++; end
    if (use_b) begin exp_b[wr_b % 64] = w; wr_b++; end
    fork
      begin
        strb_a = use_a; strb_b = use_b;
        #(hi);
        strb_a = 1'b0; strb_b = 1'b0;
      end
      begin
        #1 bus = ~w;   // R2: later bus changes must not leak through
      end
      begin
        int lat_a = 0;
        int lat_b = 0;
        for (int k = 1; k <= 6; k++) begin
          @(posedge clk); #1;
          if (val_a && lat_a == 0) lat_a = k;
          if (val_b && lat_b == 0) lat_b = k;
        end
        if (use_a) chk(lat_a == 3, "R4", "latency A", lat_a, 3);
        if (use_b) chk(lat_b == 3, "R4", "latency B", lat_b, 3);
      end
    join
    @(negedge clk); #1;
    #(gap);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs cleared under reset
    chk(val_a == 1'b0 && dout_a == '0, "R1", "reset A", int'(dout_a), 0);
    chk(val_b == 1'b0 && dout_b == '0, "R1", "reset B", int'(dout_b), 0);
    rst = 1'b0;
    @(negedge clk); #1;

    // Vector table: both front ends, strobes at least one period wide (R2, R3, R4, R6)
    for (int v = 0; v < NVEC; v++) begin
      send(VEC_WORD[v], VEC_HI[v], VEC_GAP[v], 1'b1, 1'b1);
      chk(rd_a == wr_a, "R3", "one valid per strobe A", rd_a, wr_a);
      chk(rd_b == wr_b, "R3", "one valid per strobe B", rd_b, wr_b);
    end
    // R2: last delivered word is the strobe-time value, not the inverted bus
    chk(dout_a == VEC_WORD[NVEC-1], "R2", "held word A", int'(dout_a), int'(VEC_WORD[NVEC-1]));
    chk(dout_b == VEC_WORD[NVEC-1], "R2", "held word B", int'(dout_b), int'(VEC_WORD[NVEC-1]));

    // R7: narrow strobes on the pulse-mode instance
    for (int p = 1; p <= 3; p++) begin
      send(8'h40 + 8'(p), p, 24, 1'b0, 1'b1);
      chk(rd_b == wr_b, "R7", "narrow strobe delivered", rd_b, wr_b);
      chk(dout_b == 8'h40 + 8'(p), "R7", "narrow strobe word", int'(dout_b), int'(8'h40 + 8'(p)));
    end

    // R9: long-held strobe gives a single word on both instances
    send(8'h9C, 60, 30, 1'b1, 1'b1);
    chk(rd_a == wr_a, "R9", "long strobe single word A", rd_a, wr_a);
    chk(rd_b == wr_b, "R9", "long strobe single word B", rd_b, wr_b);
    repeat (10) @(negedge clk);
    chk(rd_a == wr_a && dout_a == 8'h9C, "R9", "no repeat A", int'(dout_a), 8'h9C);
    chk(rd_b == wr_b && dout_b == 8'h9C, "R9", "no repeat B", int'(dout_b), 8'h9C);

    // R1: reset in mid-operation clears a non-zero output
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(val_a == 1'b0 && dout_a == '0, "R1", "mid reset A", int'(dout_a), 0);
    chk(val_b == 1'b0 && dout_b == '0, "R1", "mid reset B", int'(dout_b), 0);
    rst = 1'b0;
    @(negedge clk); #1;

    // Traffic after reset still flows in order (R6)
    send(8'h66, 8, 20, 1'b1, 1'b1);
    send(8'h99, 2, 20, 1'b0, 1'b1);
    chk(dout_a == 8'h66, "R6", "after reset A", int'(dout_a), 8'h66);
    chk(dout_b == 8'h99, "R6", "after reset B", int'(dout_b), 8'h99);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule